// File: doc/BRIEF.md
# Peripheral Read Response Parser

After a bus turnaround, a display serial link returns a short burst of 32-bit words from the peripheral. This block takes that burst one word at a time. It treats the first word as the packet header and reads the response kind from the header's data-type field. What it does next depends on the kind:

- For an acknowledge-with-error response, it reports the 16-bit error bitmap.
- For a short read, it emits the one or two data bytes carried inside the header.
- For a long read, it unpacks the payload words that follow the header into a byte-lane stream. The number of bytes is limited to the smaller of the size announced in the header and the receive length the host asked for.

The host supplies the total word count of the burst, including the header, together with the header word. Words beyond what the byte limit needs are still taken in, so the next header lands in the right place. When the last word of a burst has been taken, a one-cycle done pulse reports the response kind and the number of bytes delivered. A type the block does not know raises an unhandled flag on the same pulse.

Top module: `dsi_rsp_parser`

## Requirements
- R1: After reset, out_valid, out_keep, done and unhandled are low, and kind, err_bits and rx_len are zero.
- R2: The response type is taken from header bits 5:0, and bits 7:6 have no effect. The kind codes are:
  - 0x02 gives kind 1 (acknowledge and error).
  - 0x21 gives kind 2 (one-byte short read).
  - 0x22 gives kind 3 (two-byte short read).
  - 0x1A and 0x1C give kind 4 (long read).
  - Every other value gives kind 5 (unhandled).
- R3: For kind 1, err_bits reports header bits 23:8 on the done pulse, no byte beat is produced, and rx_len is 0. For every other kind, err_bits is 0.
- R4: For kind 2, one beat is produced with out_keep = 0001 and lane 0 = header bits 15:8, and rx_len is 1.
- R5: For kind 3, one beat is produced with out_keep = 0011, lane 0 = header bits 15:8 and lane 1 = header bits 23:16, and rx_len is 2.
- R6: For kind 4, the byte limit is the minimum of header bits 23:8 and max_len, with max_len sampled together with the header. rx_len equals that limit, or fewer bytes if the burst ends first.
- R7: Long-read payload words are unpacked with the least significant byte first. Lane k of payload word i (counting from 0) carries byte 4i+k. out_keep marks the lanes below the remaining limit as a contiguous run from lane 0, and lanes that are not kept read as zero.
- R8: Payload words that arrive after the limit is reached, and any words after the header for kinds other than 4, are consumed without a beat. The header that follows is parsed correctly.
- R9: word_cnt, sampled with the header, gives the burst length including the header, and a value of 0 is treated as 1. done pulses for one cycle after the edge that takes the last word, and carries kind and rx_len.
- R10: For kind 5, unhandled pulses together with done, rx_len is 0, and any payload words are consumed.
- R11: A byte beat appears in the cycle after the edge that accepts its word, and it coincides with done when that word is the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A response word is present this cycle |
| in_data | input | 32 | Response word (the header first, then the payload) |
| word_cnt | input | CNT_W | Words in the burst including the header, sampled with the header |
| max_len | input | LEN_W | Host receive length limit, sampled with the header |
| out_valid | output | 1 | Byte beat valid |
| out_data | output | 32 | Byte lanes, with lane 0 as the first byte |
| out_keep | output | 4 | Lanes that carry a valid byte |
| done | output | 1 | One-cycle end-of-response pulse |
| kind | output | 3 | Response kind code, updated on done |
| err_bits | output | 16 | Error bitmap, updated on done |
| unhandled | output | 1 | Unknown response type, pulses with done |
| rx_len | output | LEN_W | Bytes delivered, updated on done |

## Verification
The final byte beat of a response and its done pulse fall in the same cycle. This happens for a short read whose burst is only the header, and for a long read whose last payload word still carries bytes. The bench provokes both by sweeping header sizes and host limits from 0 to 9 against word counts with and without surplus words. At every word it compares the beat, the lane mask and the done pulse together against an arithmetic model. At the pulse it also checks kind, length and the error bitmap. Responses are sent back to back, so a header right after a discarded surplus word shows that the input stays aligned.

// File: rtl/dsi_rsp_parser.sv
module dsi_rsp_parser #(
  parameter int LEN_W = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      in_data,
  input  logic [CNT_W-1:0] word_cnt,
  input  logic [LEN_W-1:0] max_len,
  output logic             out_valid,
  output logic [31:0]      out_data,
  output logic [3:0]       out_keep,
  output logic             done,
  output logic [2:0]       kind,
  output logic [15:0]      err_bits,
  output logic             unhandled,
  output logic [LEN_W-1:0] rx_len
);
  localparam logic [2:0] K_ACK = 3'd1, K_S1 = 3'd2, K_S2 = 3'd3, K_LONG = 3'd4, K_UNK = 3'd5;

  logic             busy;
  logic [CNT_W-1:0] left_q;
  logic [LEN_W-1:0] lim_q, cnt_q, max_q;
  logic [2:0]       kind_q;
  logic [15:0]      err_q;

  logic [2:0]       hk;
  logic [LEN_W-1:0] hsize, hlim;
  logic [2:0]       nb;
  logic [3:0]       keep_p;
  logic [31:0]      pay_data;

  always_comb begin
    unique case (in_data[5:0])
      6'h02:        hk = K_ACK;
      6'h21:        hk = K_S1;
      6'h22:        hk = K_S2;
      6'h1A, 6'h1C: hk = K_LONG;
      default:      hk = K_UNK;
    endcase
  end

  assign hsize  = LEN_W'(in_data[23:8]);
  assign hlim   = (hsize < max_len) ? hsize : max_len;
  assign nb     = (lim_q >= LEN_W'(4)) ? 3'd4 : lim_q[2:0];
  assign keep_p = (busy && kind_q == K_LONG) ? 4'(4'b1111 >> (3'd4 - nb)) : 4'b0000;

  always_comb begin
    for (int k = 0; k < 4; k++)
      pay_data[8*k +: 8] = keep_p[k] ? in_data[8*k +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; left_q <= '0; lim_q <= '0; cnt_q <= '0; max_q <= '0;
      kind_q <= '0; err_q <= '0;
      out_valid <= 1'b0; out_data <= '0; out_keep <= '0;
      done <= 1'b0; kind <= '0; err_bits <= '0; unhandled <= 1'b0; rx_len <= '0;
    end else begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_keep  <= '0;
      done      <= 1'b0;
      unhandled <= 1'b0;
      if (in_valid) begin
        if (!busy) begin
          logic [LEN_W-1:0] c_n;
          logic [15:0]      e_n;
          c_n = '0;
          e_n = (hk == K_ACK) ? in_data[23:8] : 16'h0000;
          if (hk == K_S1) begin
            out_valid <= 1'b1; out_keep <= 4'b0001; out_data <= {24'h0, in_data[15:8]};
            c_n = LEN_W'(1);
          end else if (hk == K_S2) begin
            out_valid <= 1'b1; out_keep <= 4'b0011; out_data <= {16'h0, in_data[23:8]};
            c_n = LEN_W'(2);
          end
          kind_q <= hk;
          err_q  <= e_n;
          lim_q  <= (hk == K_LONG) ? hlim : '0;
          max_q  <= max_len;
          cnt_q  <= c_n;
          if (word_cnt <= CNT_W'(1)) begin
            done <= 1'b1; kind <= hk; rx_len <= c_n; err_bits <= e_n;
            unhandled <= (hk == K_UNK);
          end else begin
            busy   <= 1'b1;
            left_q <= word_cnt - CNT_W'(1);
          end
        end else begin
          out_valid <= (keep_p != 4'b0000);
          out_keep  <= keep_p;
          out_data  <= pay_data;
          lim_q     <= lim_q - LEN_W'(nb);
          cnt_q     <= cnt_q + LEN_W'(nb);
          left_q    <= left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) begin
            busy <= 1'b0; done <= 1'b1; kind <= kind_q;
            rx_len <= cnt_q + LEN_W'(nb); err_bits <= err_q;
            unhandled <= (kind_q == K_UNK);
          end
        end
      end
    end
  end

  a_r7_keep_contig: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_keep != 4'b0000 && (out_keep & (out_keep + 4'd1)) == 4'b0000));

  a_r6_len_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind == K_LONG) |-> rx_len <= max_q);

  a_r10_unhandled_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    unhandled |-> (done && kind == K_UNK && rx_len == '0));

  a_r3_ack_no_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind == K_ACK) |-> rx_len == '0);

  a_r5_short2_len: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind == K_S2) |-> rx_len == LEN_W'(2));

  a_r8_no_beat_when_idle_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_keep[2]) |-> kind_q == K_LONG);
endmodule

// File: tb/dsi_rsp_parser_tb_top.sv
`timescale 1ns/1ps
module dsi_rsp_parser_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic [4:0]  word_cnt = '0;
  logic [15:0] max_len = '0;
  logic        out_valid, done, unhandled;
  logic [31:0] out_data;
  logic [3:0]  out_keep;
  logic [2:0]  kind;
  logic [15:0] err_bits, rx_len;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  dsi_rsp_parser #(.LEN_W(16), .CNT_W(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .word_cnt(word_cnt), .max_len(max_len), .out_valid(out_valid),
    .out_data(out_data), .out_keep(out_keep), .done(done), .kind(kind),
    .err_bits(err_bits), .unhandled(unhandled), .rx_len(rx_len));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int kof(input int dt);
    case (dt)
      8'h02: return 1;
      8'h21: return 2;
      8'h22: return 3;
      8'h1A, 8'h1C: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic logic [7:0] pat(input int j, input int seed);
    return 8'((j * 37 + seed * 11 + 5) & 255);
  endfunction

  task automatic run_rsp(input int dt, input int ch, input int mid, input int ml,
                         input int nw, input int seed, input string tag);
    int ek = kof(dt);
    int lim = (mid < ml) ? mid : ml;
    int nwe = (nw < 1) ? 1 : nw;
    int elen;
    if (ek == 4) elen = (lim < 4 * (nwe - 1)) ? lim : 4 * (nwe - 1);
    else if (ek == 2) elen = 1;
    else if (ek == 3) elen = 2;
    else elen = 0;
    for (int w = 0; w < nwe; w++) begin
      logic [31:0] d, edata;
      logic [3:0]  ekeep;
      bit          ev, edone;
      if (w == 0) d = {8'h00, 16'(mid), 2'(ch), 6'(dt)};
      else for (int k = 0; k < 4; k++) d[8*k +: 8] = pat(4 * (w - 1) + k, seed);
      @(negedge clk);
      in_valid = 1'b1; in_data = d; word_cnt = 5'(nw); max_len = 16'(ml);
      @(posedge clk); #1;
      ekeep = 4'b0000; edata = '0;
      if (w == 0 && ek == 2) begin ekeep = 4'b0001; edata = {24'h0, d[15:8]}; end
      if (w == 0 && ek == 3) begin ekeep = 4'b0011; edata = {16'h0, d[23:8]}; end
      if (w > 0 && ek == 4) begin
        int rem = lim - 4 * (w - 1);
        int n = (rem < 0) ? 0 : ((rem > 4) ? 4 : rem);
        for (int k = 0; k < n; k++) begin ekeep[k] = 1'b1; edata[8*k +: 8] = d[8*k +: 8]; end
      end
      ev = (ekeep != 4'b0000);
      edone = (w == nwe - 1);
      // R7 R4 R5 R8 R11 beat and R9 done timing
      chk(out_valid == ev && out_keep == ekeep && out_data == edata && done == edone,
          $sformatf("%s beat w%0d", tag, w),
          {out_valid, done, 2'b0, out_keep, 24'h0, out_data},
          {ev, edone, 2'b0, ekeep, 24'h0, edata});
    end
    // R2 R3 R6 R10 completion fields
    chk(kind == 3'(ek) && rx_len == 16'(elen) && err_bits == ((ek == 1) ? 16'(mid) : 16'h0)
        && unhandled == (ek == 5), $sformatf("%s R2/R3/R6/R10 done fields dt=%0h", tag, dt),
        {unhandled, 3'b0, kind, 8'h0, err_bits, rx_len},
        {(ek == 5), 3'b0, 3'(ek), 8'h0, ((ek == 1) ? 16'(mid) : 16'h0), 16'(elen)});
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!out_valid && out_keep == 0 && !done && !unhandled && kind == 0 && err_bits == 0 && rx_len == 0,
        "R1 reset", {out_valid, done, unhandled, kind, err_bits, rx_len}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !done && kind == 0 && rx_len == 0, "R1 after release",
        {out_valid, done, kind, rx_len}, 0);
    // R2 R3 R4 R5 R10 full data-type sweep, channel bits varied, burst lengths 1..3
    for (int dt = 0; dt < 64; dt++)
      run_rsp(dt, dt % 4, 16'hA5C3 ^ dt, 3, 1 + (dt % 3), dt, "R2 type sweep");
    // R6 R7 R8 long-read size x limit sweep, surplus words on some
    for (int t = 0; t < 2; t++)
      for (int sz = 0; sz < 10; sz++)
        for (int ml = 0; ml < 10; ml++)
          run_rsp(t ? 8'h1C : 8'h1A, sz % 4, sz, ml, 1 + (sz + 3) / 4 + ((sz % 3 == 0) ? 1 : 0),
                  sz * 10 + ml, "R6 R7 long sweep");
    // R6 limit from host with a large header size, R8 surplus discarded
    run_rsp(8'h1C, 1, 300, 5, 4, 7, "R6 R8 big size");
    // R6 burst shorter than the limit
    run_rsp(8'h1A, 0, 6, 100, 2, 9, "R6 short burst");
    // R9 word count zero treated as one
    run_rsp(8'h21, 2, 16'h3C5A, 0, 0, 1, "R9 zero count");
    // R3 ack with surplus words, then R10 unknown with payload
    run_rsp(8'h02, 3, 16'hFFFF, 8, 3, 2, "R3 R8 ack surplus");
    run_rsp(8'h3F, 0, 16'h1234, 8, 4, 3, "R10 unknown payload");
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    chk(!out_valid && !done, "R11 idle after burst", {out_valid, done}, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule